// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Block

This block gathers interrupt events for a two-channel storage host controller. Each channel has two sources: the attached device and the bus-master transfer engine. Each source raises a one-cycle pulse. The block turns every pulse into a sticky status bit and keeps a mask bit for each channel. It drives one combined interrupt line, which asserts while any status bit on an unmasked channel is set.

Host software reaches the block through a small byte-wide register window: a select strobe, a write flag, a 2-bit offset and 8-bit write and read data. Two byte locations carry the channel status. The second of those bytes also carries both mask bits and a board strap that says whether a legacy header is fitted.

A write to the first status location does not touch status. It loads a separate write-only mode byte, which is driven out to neighbouring logic. One bit of that byte sets the polarity of the interrupt line. Status bits are cleared by per-source acknowledge inputs from the channel logic, not by register writes.

Top module: `dirq_top`

## Requirements
- R1: After reset, all status bits, both masks, the mode byte and the read data are 0, and the interrupt line is low.
- R2: Reading offset 2 returns the channel 0 device status in bit 0 and the channel 0 bus-master status in bit 1. A status bit is set by a one-cycle pulse and stays set after the pulse ends. Bits 7:2 read 0.
- R3: Reading offset 3 returns the channel 1 device status in bit 2 and the channel 1 bus-master status in bit 3.
- R4: An acknowledge input clears the matching status bit. When a pulse and an acknowledge for the same bit arrive in the same cycle, the bit is set.
- R5: Bits 1:0 of offset 3 are the channel 1 and channel 0 mask bits (bit 1 is channel 1, bit 0 is channel 0), and they can be written and read back. A write to offset 3 does not change the status bits in bits 3:2.
- R6: Bit 4 of offset 3 reads the legacy-header strap input at the time of the read. Bits 7:5 of offset 3 read 0.
- R7: A channel mask bit of 1 keeps that channel's status from the interrupt line. The line asserts when any status bit of an unmasked channel is set.
- R8: Mode byte bit 2 selects the polarity of the interrupt line: 0 is active-high, which is the reset value, and 1 is active-low.
- R9: A write to offset 2 loads all 8 bits into the mode byte output and leaves the status readback unchanged.
- R10: Read data is registered. It updates on the clock edge that samples a read strobe and holds its value at all other times. Offsets 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrqPulse | input | 2 | Device interrupt event, one bit per channel |
| dmaDonePulse | input | 2 | Bus-master completion event, one bit per channel |
| devAck | input | 2 | Clears the device status, one bit per channel |
| dmaAck | input | 2 | Clears the bus-master status, one bit per channel |
| legacyStrap | input | 1 | Legacy-header present strap |
| regSel | input | 1 | Register access strobe, one cycle |
| regWr | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 2 | Byte offset of the access |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Registered read data |
| modeOut | output | 8 | Write-only mode byte |
| irqLine | output | 1 | Combined interrupt line, polarity set by the mode byte |

## Verification
An event or acknowledge pulse changes status on the edge that samples it. The interrupt line follows in the same cycle, because it is combinational from the status, mask and mode flops. A register read needs one more edge for the read-data flop, and a mask or mode write takes effect on the edge that samples the strobe. The bench drives every input on the falling edge and holds it for one full period. It checks the interrupt line and the mode byte on the falling edge after the stimulus. It checks read data on the falling edge after the edge that sampled the read, so every check lands half a period after the result is due.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  // Register layout and sizes
  localparam int NCH       = 2;
  localparam int DW        = 8;
  localparam int AW        = 2;
  localparam int STAT_OFS  = 2;   // channel 0 status read, mode byte write
  localparam int MASK_OFS  = 3;   // channel 1 status, masks, strap
  localparam int MASK_LSB  = 0;
  localparam int ST1_LSB   = 2;
  localparam int STRAP_BIT = 4;
  localparam int POL_BIT   = 2;   // mode byte: 1 = active-low line

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_CH0  = 2'd1,
    RD_CH1  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrMode;
    logic   rdEn;
    rdSrc_e rdSrc;
  } regStb_t;
endpackage

// File: rtl/dirq_ctrl.sv
module dirq_ctrl
  import dirq_pkg::*;
(
  input  logic          regSel,
  input  logic          regWr,
  input  logic [AW-1:0] regAddr,
  output regStb_t       stb
);
  localparam logic [AW-1:0] StatAddr = AW'(STAT_OFS);
  localparam logic [AW-1:0] MaskAddr = AW'(MASK_OFS);

  logic isStat;
  logic isMask;

  assign isStat = (regAddr == StatAddr);
  assign isMask = (regAddr == MaskAddr);

  always_comb begin
    stb        = '0;
    stb.wrMask = regSel & regWr & isMask;
    stb.wrMode = regSel & regWr & isStat;
    stb.rdEn   = regSel & ~regWr;
    if (isStat)      stb.rdSrc = RD_CH0;
    else if (isMask) stb.rdSrc = RD_CH1;
    else             stb.rdSrc = RD_ZERO;
  end
endmodule

// File: rtl/dirq_datapath.sv
module dirq_datapath
  import dirq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] devPulse,
  input  logic [NCH-1:0] bmPulse,
  input  logic [NCH-1:0] devClr,
  input  logic [NCH-1:0] bmClr,
  input  logic           strap,
  input  regStb_t        stb,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] devStat,
  output logic [NCH-1:0] bmStat,
  output logic [NCH-1:0] maskQ,
  output logic [DW-1:0]  modeQ,
  output logic           irqLine
);
  localparam int PadCh0 = DW - 2;
  localparam int PadCh1 = DW - STRAP_BIT - 1;

  // Sticky status, one pair of flops per channel; set beats clear
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic devQ;
    logic bmQ;
    always_ff @(posedge clk) begin
      if (!rstN)              devQ <= 1'b0;
      else if (devPulse[ch])  devQ <= 1'b1;
      else if (devClr[ch])    devQ <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)              bmQ <= 1'b0;
      else if (bmPulse[ch])   bmQ <= 1'b1;
      else if (bmClr[ch])     bmQ <= 1'b0;
    end
    assign devStat[ch] = devQ;
    assign bmStat[ch]  = bmQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.wrMask) maskQ <= wdata[MASK_LSB +: NCH];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           modeQ <= '0;
    else if (stb.wrMode) modeQ <= wdata;
  end

  logic [DW-1:0] rdNext;
  always_comb begin
    unique case (stb.rdSrc)
      RD_CH0:  rdNext = {{PadCh0{1'b0}}, bmStat[0], devStat[0]};
      RD_CH1:  rdNext = {{PadCh1{1'b0}}, strap, bmStat[1], devStat[1],
                         maskQ[1], maskQ[0]};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdata <= '0;
    else if (stb.rdEn) rdata <= rdNext;
  end

  logic anyPend;
  assign anyPend = |((devStat | bmStat) & ~maskQ);
  assign irqLine = anyPend ^ modeQ[POL_BIT];
endmodule

// File: rtl/dirq_top.sv
module dirq_top
  import dirq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] devIrqPulse,
  input  logic [NCH-1:0] dmaDonePulse,
  input  logic [NCH-1:0] devAck,
  input  logic [NCH-1:0] dmaAck,
  input  logic           legacyStrap,
  input  logic           regSel,
  input  logic           regWr,
  input  logic [AW-1:0]  regAddr,
  input  logic [DW-1:0]  regWdata,
  output logic [DW-1:0]  regRdata,
  output logic [DW-1:0]  modeOut,
  output logic           irqLine
);
  regStb_t        stb;
  logic [NCH-1:0] devStat;
  logic [NCH-1:0] bmStat;
  logic [NCH-1:0] maskQ;

  dirq_ctrl u_ctrl (
    .regSel  (regSel),
    .regWr   (regWr),
    .regAddr (regAddr),
    .stb     (stb)
  );

  dirq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .devPulse (devIrqPulse),
    .bmPulse  (dmaDonePulse),
    .devClr   (devAck),
    .bmClr    (dmaAck),
    .strap    (legacyStrap),
    .stb      (stb),
    .wdata    (regWdata),
    .rdata    (regRdata),
    .devStat  (devStat),
    .bmStat   (bmStat),
    .maskQ    (maskQ),
    .modeQ    (modeOut),
    .irqLine  (irqLine)
  );
endmodule

// File: rtl/dirq_chk.sv
module dirq_chk
  import dirq_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] devIrqPulse,
  input logic [NCH-1:0] devAck,
  input logic           legacyStrap,
  input logic           regSel,
  input logic           regWr,
  input logic [AW-1:0]  regAddr,
  input logic [DW-1:0]  regRdata,
  input logic [DW-1:0]  modeOut,
  input logic           irqLine,
  input logic [NCH-1:0] devStat,
  input logic [NCH-1:0] maskQ
);
  localparam logic [AW-1:0] StatAddr = AW'(STAT_OFS);
  localparam logic [AW-1:0] MaskAddr = AW'(MASK_OFS);

  // R2
  dev_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    devIrqPulse[0] |=> devStat[0]);

  // R4
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devAck[1] && !devIrqPulse[1]) |=> !devStat[1]);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWr && regAddr == MaskAddr) |=> $stable(maskQ));

  // R6
  strap_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && regAddr == MaskAddr) |=> (regRdata[STRAP_BIT] == $past(legacyStrap)));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1 && !modeOut[POL_BIT]) |-> !irqLine);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWr && regAddr == StatAddr) |=> $stable(modeOut));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && !regWr) |=> $stable(regRdata));
endmodule

bind dirq_top dirq_chk u_dirqChk (
  .clk         (clk),
  .rstN        (rstN),
  .devIrqPulse (devIrqPulse),
  .devAck      (devAck),
  .legacyStrap (legacyStrap),
  .regSel      (regSel),
  .regWr       (regWr),
  .regAddr     (regAddr),
  .regRdata    (regRdata),
  .modeOut     (modeOut),
  .irqLine     (irqLine),
  .devStat     (devStat),
  .maskQ       (maskQ)
);

// File: tb/dirq_top_bench.sv
`timescale 1ns/1ps
module dirq_top_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] devIrqPulse, dmaDonePulse, devAck, dmaAck;
  logic       legacyStrap, regSel, regWr;
  logic [1:0] regAddr;
  logic [7:0] regWdata, regRdata, modeOut;
  logic       irqLine;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;

  dirq_top u_dirq_top (
    .clk(clk), .rstN(rstN), .devIrqPulse(devIrqPulse), .dmaDonePulse(dmaDonePulse),
    .devAck(devAck), .dmaAck(dmaAck), .legacyStrap(legacyStrap), .regSel(regSel),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .modeOut(modeOut), .irqLine(irqLine)
  );

  // {devP, bmP, devA, bmA, expOfs2, expOfs3, expIrq}; strap = 1, masks 0
  localparam int NVEC = 6;
  localparam logic [24:0] VEC [NVEC] = '{
    {2'b01, 2'b00, 2'b00, 2'b00, 8'h01, 8'h10, 1'b1},
    {2'b00, 2'b10, 2'b00, 2'b00, 8'h01, 8'h18, 1'b1},
    {2'b00, 2'b00, 2'b01, 2'b00, 8'h00, 8'h18, 1'b1},
    {2'b10, 2'b00, 2'b00, 2'b10, 8'h00, 8'h14, 1'b1},
    {2'b10, 2'b01, 2'b10, 2'b00, 8'h02, 8'h14, 1'b1},
    {2'b00, 2'b00, 2'b10, 2'b01, 8'h00, 8'h10, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic events(input logic [1:0] dp, input logic [1:0] bp,
                        input logic [1:0] da, input logic [1:0] ba);
    devIrqPulse = dp; dmaDonePulse = bp; devAck = da; dmaAck = ba;
    @(negedge clk);
    devIrqPulse = '0; dmaDonePulse = '0; devAck = '0; dmaAck = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    @(negedge clk);
    regSel = 1'b0;
    d = regRdata;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; devIrqPulse = '0; dmaDonePulse = '0; devAck = '0; dmaAck = '0;
    legacyStrap = 1'b1; regSel = 1'b0; regWr = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqLine", {7'b0, irqLine}, 8'h00);
    check("R1 modeOut", modeOut, 8'h00);
    check("R1 rdata", regRdata, 8'h00);
    regRead(2'd2, rd); check("R1 ofs2", rd, 8'h00);

    // R2 R3 R4 R7 vector walk
    for (int i = 0; i < NVEC; i++) begin
      events(VEC[i][24:23], VEC[i][22:21], VEC[i][20:19], VEC[i][18:17]);
      check($sformatf("R7 irq vec%0d", i), {7'b0, irqLine}, {7'b0, VEC[i][0]});
      regRead(2'd2, rd); check($sformatf("R2 R4 ofs2 vec%0d", i), rd, VEC[i][16:9]);
      regRead(2'd3, rd); check($sformatf("R3 R4 ofs3 vec%0d", i), rd, VEC[i][8:1]);
    end

    // R6 strap readback both values
    legacyStrap = 1'b0;
    regRead(2'd3, rd); check("R6 strap0", rd, 8'h00);

    // R5 masks writable, read-only bits ignore writes
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, rd); check("R5 mask set", rd, 8'h03);
    events(2'b01, 2'b00, 2'b00, 2'b00);
    check("R7 masked quiet", {7'b0, irqLine}, 8'h00);
    regWrite(2'd3, 8'h02);
    check("R7 unmasked ch0", {7'b0, irqLine}, 8'h01);
    events(2'b10, 2'b00, 2'b00, 2'b00);
    regWrite(2'd3, 8'h00);
    regRead(2'd3, rd); check("R5 status kept", rd, 8'h04);

    // R8 R9 mode byte and polarity
    regWrite(2'd2, 8'h84);
    check("R9 modeOut", modeOut, 8'h84);
    check("R8 active-low asserted", {7'b0, irqLine}, 8'h00);
    regRead(2'd2, rd); check("R9 ofs2 unchanged", rd, 8'h01);
    events(2'b00, 2'b00, 2'b11, 2'b00);
    check("R8 active-low idle", {7'b0, irqLine}, 8'h01);
    regWrite(2'd2, 8'h80);
    check("R8 active-high idle", {7'b0, irqLine}, 8'h00);

    // R10 unmapped offsets and hold
    legacyStrap = 1'b1;
    regRead(2'd3, rd); check("R6 strap1", rd, 8'h10);
    regRead(2'd0, rd); check("R10 ofs0", rd, 8'h00);
    regRead(2'd3, rd);
    events(2'b01, 2'b00, 2'b00, 2'b00);
    repeat (2) @(negedge clk);
    check("R10 hold", regRdata, 8'h10);
    regRead(2'd1, rd); check("R10 ofs1", rd, 8'h00);

    // R4 set wins on ch0 bus-master
    events(2'b00, 2'b01, 2'b00, 2'b01);
    regRead(2'd2, rd); check("R4 set wins", rd, 8'h03);

    // R1 reset again clears everything
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 modeOut rerst", modeOut, 8'h00);
    check("R1 irq rerst", {7'b0, irqLine}, 8'h00);
    regRead(2'd2, rd); check("R1 ofs2 rerst", rd, 8'h00);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule